// File: doc/BRIEF.md
# Register Table Loader Engine

This block is a hardware sequencer that turns a compact configuration table into a series of register writes. The table sits in a small synchronous ROM. The engine reads it through a read port with an address output and a data input, and the data returns one cycle after the address is presented. Each table word is either a data word, an address-jump marker, or an end marker. The first word of the table is the starting target address. A data word is written to the current address, and the address then steps forward by one word. A jump marker takes the word that follows it as the new address. The end marker closes the table.

When `start` is pulsed, the engine first clears a control register by writing zero to a fixed address. It then stays quiet on the bus for a programmed number of cycles, and after that it walks the table. After a clean end it performs one read-modify-write on a fixed register: the low refresh-timing field is replaced with a configured value, and the upper bits are kept.

A target address below the register block base stops the run at once with an error. Reaching the end of the table without an end marker also stops the run with an error. In both cases `done` is raised together with `err`, and the read-modify-write is skipped.

The register bus is a request channel with `bus_wr` or `bus_rd` as valid and `bus_ready` as ready. A request holds its strobe, address and write data unchanged until the cycle in which `bus_ready` is high, and that cycle completes the transfer. Only one request is outstanding at a time. The bus can apply back-pressure indefinitely.

Top module: `cfg_table_loader`

## Requirements
- R1: Out of reset, `done`, `err`, `bus_wr` and `bus_rd` are all low.
- R2: After `start` is accepted, the first bus transfer is a write of zero to `PHY_CTRL_ADDR`. No bus transfer then occurs for at least `DELAY_CYC`+1 cycles after that write completes.
- R3: Table word 0 is the starting address and parsing begins at word 1. Each data word is written to the current address, and the address then increases by 4.
- R4: A word equal to `END_MARK` (all ones by default) stops the parse and is not written. Words that differ from both markers are written, even when they are zero or one less than `JUMP_MARK`.
- R5: A word equal to `JUMP_MARK` (0xFFFF_FFFE by default) makes the following word the current address. Neither the marker nor the address word is written. Consecutive jumps are allowed.
- R6: The current address is checked before every table word is consumed. If it is below `BASE_ADDR`, the run ends with `done`=1 and `err`=1, and no further writes or patch happen. Writes already made stay as they are.
- R7: If all `DEPTH` table words are consumed without an end marker, including a jump marker in the last word, the run ends with `done`=1 and `err`=1 and no patch.
- R8: After a clean end the engine reads `BASE_ADDR`+`PATCH_OFS`. It then writes back the read value with bits `FIELD_W`-1:0 replaced by `REFRESH_VAL`, and raises `done` with `err`=0.
- R9: While a request waits for `bus_ready`, its strobe, address and write data stay unchanged, and `bus_wr` and `bus_rd` are never high together.
- R10: `start` has no effect while a run is in progress. `done` and `err` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load run (accepted only when idle) |
| done | output | 1 | Run finished; holds until next start |
| err | output | 1 | Run aborted (address below base or table overrun) |
| rom_addr | output | $clog2(DEPTH) | Table ROM word address |
| rom_data | input | W | Table word, valid one cycle after `rom_addr` |
| bus_wr | output | 1 | Write request valid |
| bus_rd | output | 1 | Read request valid |
| bus_addr | output | W | Request byte address |
| bus_wdata | output | W | Write data |
| bus_rdata | input | W | Read data, valid when `bus_ready` is high |
| bus_ready | input | 1 | Completes the pending request |

## Verification
The hardest cases to reach from the ports are the ones where the table ends badly. Examples are a jump marker in the very last table word, a jump to an address just below the base after some writes have already been made, and a run of consecutive jumps. The bench builds these tables by hand. It also generates a set of mixed tables from a shift-register sequence, so that markers land at varied positions and the bus response latency varies from one table to the next. For every table, a behavioural walk in the bench predicts the exact write list, the error flag and the patch value. A second `start` is also pulsed in the middle of the quiet delay to show that it has no effect.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PHY, S_DLY, S_BASE, S_CHK, S_EVAL,
    S_JWAIT, S_JADDR, S_WR, S_PRD, S_PWR
  } ldr_state_t;

  typedef enum logic [1:0] {
    W_DATA, W_JUMP, W_END
  } word_kind_t;
endpackage

// File: rtl/ldr_bus_port.sv
module ldr_bus_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic         is_wr,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_data,
  input  logic         bus_ready,
  output logic         bus_wr,
  output logic         bus_rd,
  output logic [W-1:0] bus_addr,
  output logic [W-1:0] bus_wdata,
  output logic         ack
);
  assign ack = (bus_wr | bus_rd) & bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (issue) begin
      bus_wr    <= is_wr;
      bus_rd    <= !is_wr;
      bus_addr  <= req_addr;
      bus_wdata <= req_data;
    end else if (ack) begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ready) |=>
      (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd)) &&
      $stable(bus_addr) && $stable(bus_wdata));

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
endmodule

// File: rtl/ldr_delay.sv
module ldr_delay #(
  parameter int DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0) && !load;

  // R2
  delay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);
endmodule

// File: rtl/ldr_word_class.sv
module ldr_word_class
  import cfg_loader_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [W-1:0] END_MARK  = '1,
  parameter logic [W-1:0] JUMP_MARK = {{(W-1){1'b1}}, 1'b0}
) (
  input  logic [W-1:0] word,
  output word_kind_t   kind
);
  always_comb begin
    if (word == END_MARK)       kind = W_END;
    else if (word == JUMP_MARK) kind = W_JUMP;
    else                        kind = W_DATA;
  end
endmodule

// File: rtl/cfg_table_loader.sv
module cfg_table_loader
  import cfg_loader_pkg::*;
#(
  parameter int           W             = 32,
  parameter int           DEPTH         = 32,
  parameter int           DELAY_CYC     = 16,
  parameter logic [W-1:0] BASE_ADDR     = 32'h0000_1000,
  parameter logic [W-1:0] PHY_CTRL_ADDR = 32'h0000_0060,
  parameter logic [W-1:0] PATCH_OFS     = 32'h0000_0084,
  parameter logic [W-1:0] END_MARK      = 32'hFFFF_FFFF,
  parameter logic [W-1:0] JUMP_MARK     = 32'hFFFF_FFFE,
  parameter int           FIELD_W       = 17,
  parameter logic [FIELD_W-1:0] REFRESH_VAL = 17'h00C30,
  localparam int          RA_W          = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            err,
  output logic [RA_W-1:0] rom_addr,
  input  logic [W-1:0]    rom_data,
  output logic            bus_wr,
  output logic            bus_rd,
  output logic [W-1:0]    bus_addr,
  output logic [W-1:0]    bus_wdata,
  input  logic [W-1:0]    bus_rdata,
  input  logic            bus_ready
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
  localparam logic [W-1:0] PATCH_ADDR = BASE_ADDR + PATCH_OFS;
  localparam logic [W-1:0] KEEP_MASK  = {{(W-FIELD_W){1'b1}}, {FIELD_W{1'b0}}};
  localparam logic [W-1:0] FIELD_VAL  = {{(W-FIELD_W){1'b0}}, REFRESH_VAL};

  ldr_state_t     state_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]   cur_q;
  logic           done_q, err_q;

  logic           iss, iss_wr, ack, dly_done;
  logic [W-1:0]   iss_addr, iss_data;
  word_kind_t     kind;

  ldr_word_class #(.W(W), .END_MARK(END_MARK), .JUMP_MARK(JUMP_MARK)) u_class (
    .word (rom_data),
    .kind (kind)
  );

  ldr_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state_q == S_PHY && ack),
    .expired (dly_done)
  );

  ldr_bus_port #(.W(W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (iss),
    .is_wr     (iss_wr),
    .req_addr  (iss_addr),
    .req_data  (iss_data),
    .bus_ready (bus_ready),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ack       (ack)
  );

  assign rom_addr = idx_q[RA_W-1:0];
  assign done     = done_q;
  assign err      = err_q;

  always_comb begin
    iss      = 1'b0;
    iss_wr   = 1'b1;
    iss_addr = '0;
    iss_data = '0;
    unique case (state_q)
      S_IDLE: if (start) begin
        iss      = 1'b1;
        iss_addr = PHY_CTRL_ADDR;
      end
      S_EVAL: begin
        if (kind == W_DATA) begin
          iss      = 1'b1;
          iss_addr = cur_q;
          iss_data = rom_data;
        end else if (kind == W_END) begin
          iss      = 1'b1;
          iss_wr   = 1'b0;
          iss_addr = PATCH_ADDR;
        end
      end
      S_PRD: if (ack) begin
        iss      = 1'b1;
        iss_addr = PATCH_ADDR;
        iss_data = (bus_rdata & KEEP_MASK) | FIELD_VAL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          idx_q   <= '0;
          state_q <= S_PHY;
        end
        S_PHY:  if (ack) state_q <= S_DLY;
        S_DLY:  if (dly_done) state_q <= S_BASE;
        S_BASE: begin
          cur_q   <= rom_data;
          idx_q   <= idx_q + 1'b1;
          state_q <= S_CHK;
        end
        S_CHK: begin
          if (cur_q < BASE_ADDR || idx_q == IDX_END) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          idx_q <= idx_q + 1'b1;
          if (kind == W_END) begin
            state_q <= S_PRD;
          end else if (kind == W_JUMP) begin
            if (idx_q == IDX_LAST) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_JWAIT;
            end
          end else begin
            state_q <= S_WR;
          end
        end
        S_JWAIT: state_q <= S_JADDR;
        S_JADDR: begin
          cur_q   <= rom_data;
          idx_q   <= idx_q + 1'b1;
          state_q <= S_CHK;
        end
        S_WR: if (ack) begin
          cur_q   <= cur_q + W'(4);
          state_q <= S_CHK;
        end
        S_PRD: if (ack) state_q <= S_PWR;
        S_PWR: if (ack) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R6
  no_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR && bus_wr) |-> (bus_addr >= BASE_ADDR));

  // R2
  quiet_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DLY) |-> (!bus_wr && !bus_rd));

  // R8
  patch_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PWR && bus_wr) |->
      (bus_wdata[FIELD_W-1:0] == REFRESH_VAL && bus_addr == PATCH_ADDR));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/cfg_table_loader_bench.sv
module cfg_table_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 32;
  localparam int DEPTH = 16;
  localparam int DLY   = 6;
  localparam int RA_W  = $clog2(DEPTH);
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] PHY  = 32'h0000_0060;
  localparam logic [31:0] OFS  = 32'h0000_0084;
  localparam logic [31:0] ENDM = 32'hFFFF_FFFF;
  localparam logic [31:0] JMPM = 32'hFFFF_FFFE;
  localparam int FW = 17;
  localparam logic [16:0] REFV = 17'h00C30;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, err, bus_wr, bus_rd, bus_ready;
  logic [RA_W-1:0] rom_addr;
  logic [31:0] rom_q, bus_addr, bus_wdata, bus_rdata;

  logic [31:0] tbl [DEPTH];
  logic [31:0] rdv = 32'h0;
  int lat = 0;
  int wcnt = 0;
  int cyc = 0;
  int hold_viol = 0;
  logic [31:0] prev_addr, prev_data;
  logic prev_wait = 1'b0;

  logic [31:0] lg_addr [LOGN];
  logic [31:0] lg_data [LOGN];
  logic        lg_wr   [LOGN];
  int          lg_cyc  [LOGN];
  int lg_n = 0;

  logic [31:0] exp_a [DEPTH];
  logic [31:0] exp_d [DEPTH];
  int exp_n;
  logic exp_err;

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_table_loader #(
    .W(W), .DEPTH(DEPTH), .DELAY_CYC(DLY), .BASE_ADDR(BASE),
    .PHY_CTRL_ADDR(PHY), .PATCH_OFS(OFS), .END_MARK(ENDM),
    .JUMP_MARK(JMPM), .FIELD_W(FW), .REFRESH_VAL(REFV)
  ) u_cfg_table_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .rom_addr(rom_addr), .rom_data(rom_q),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  assign bus_ready = (bus_wr || bus_rd) && (wcnt >= lat);
  assign bus_rdata = rdv;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rom_q <= tbl[rom_addr];
    if (bus_wr && bus_rd) hold_viol <= hold_viol + 1;
    if (prev_wait && (bus_addr !== prev_addr || bus_wdata !== prev_data ||
                      !(bus_wr || bus_rd)))
      hold_viol <= hold_viol + 1;
    prev_wait <= (bus_wr || bus_rd) && !bus_ready;
    prev_addr <= bus_addr;
    prev_data <= bus_wdata;
    if ((bus_wr || bus_rd) && bus_ready) begin
      if (lg_n < LOGN) begin
        lg_addr[lg_n] <= bus_addr;
        lg_data[lg_n] <= bus_wdata;
        lg_wr[lg_n]   <= bus_wr;
        lg_cyc[lg_n]  <= cyc;
      end
      lg_n <= lg_n + 1;
      wcnt <= 0;
    end else if (bus_wr || bus_rd) begin
      wcnt <= wcnt + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Behavioural walk of the table, derived from R3..R7.
  task automatic model();
    logic [31:0] a, d;
    int i;
    a = tbl[0]; i = 1; exp_n = 0; exp_err = 1'b0;
    forever begin
      if (a < BASE)     begin exp_err = 1'b1; break; end
      if (i >= DEPTH)   begin exp_err = 1'b1; break; end
      d = tbl[i]; i++;
      if (d == ENDM) break;
      if (d == JMPM) begin
        if (i >= DEPTH) begin exp_err = 1'b1; break; end
        a = tbl[i]; i++;
      end else begin
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
        a = a + 32'd4;
      end
    end
  endtask

  task automatic run(input string tag, input logic poke_start);
    int s, k, to, exp_total;
    logic [31:0] pv;
    model();
    s = lg_n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R10 done cleared by start", {31'b0, done}, 32'd0);
    if (poke_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    to = 0;
    while (!done && to < 3000) begin @(negedge clk); to++; end
    check(done == 1'b1, {"R10 run finished ", tag}, {31'b0, done}, 32'd1);
    check(err == exp_err, {exp_err ? "R6/R7 err flag " : "R8 err clear ", tag},
          {31'b0, err}, {31'b0, exp_err});
    exp_total = 1 + exp_n + (exp_err ? 0 : 2);
    check(lg_n - s == exp_total, {"R3 transfer count ", tag}, lg_n - s, exp_total);
    if (lg_n - s == exp_total) begin
      check(lg_wr[s] && lg_addr[s] == PHY && lg_data[s] == 32'd0,
            {"R2 control clear ", tag}, lg_addr[s], PHY);
      if (exp_total > 1)
        check(lg_cyc[s+1] - lg_cyc[s] >= DLY + 1, {"R2 quiet gap ", tag},
              lg_cyc[s+1] - lg_cyc[s], DLY + 1);
      for (int j = 0; j < exp_n; j++) begin
        k = s + 1 + j;
        check(lg_wr[k] && lg_addr[k] == exp_a[j], {"R3 R5 write addr ", tag},
              lg_addr[k], exp_a[j]);
        check(lg_data[k] == exp_d[j], {"R3 R4 write data ", tag},
              lg_data[k], exp_d[j]);
      end
      if (!exp_err) begin
        k = s + 1 + exp_n;
        pv = (rdv & 32'hFFFE_0000) | {15'b0, REFV};
        check(!lg_wr[k] && lg_addr[k] == BASE + OFS, {"R8 patch read ", tag},
              lg_addr[k], BASE + OFS);
        check(lg_wr[k+1] && lg_addr[k+1] == BASE + OFS && lg_data[k+1] == pv,
              {"R8 patch write ", tag}, lg_data[k+1], pv);
      end
    end
    repeat (4) @(negedge clk);
    check(done == 1'b1 && err == exp_err, {"R10 flags hold ", tag},
          {30'b0, done, err}, {30'b0, 1'b1, exp_err});
  endtask

  task automatic fill(input logic [31:0] v);
    for (int i = 0; i < DEPTH; i++) tbl[i] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    fill(ENDM);
    repeat (3) @(negedge clk);
    check(!done && !err && !bus_wr && !bus_rd, "R1 reset state",
          {28'b0, done, err, bus_wr, bus_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: contiguous data under several bus latencies
    for (int l = 0; l < 4; l++) begin
      lat = l; rdv = 32'hA5A5_5A5A + l;
      fill(ENDM);
      tbl[0] = BASE + 32'h10; tbl[1] = 32'h1111; tbl[2] = 32'h2222; tbl[3] = 32'h3333;
      run("contiguous", 1'b0);
    end
    lat = 1; rdv = 32'hFFFF_FFFF;
    // R5: chained jumps
    fill(ENDM);
    tbl[0] = BASE + 32'h100; tbl[1] = 32'hD0; tbl[2] = JMPM; tbl[3] = BASE + 32'h200;
    tbl[4] = 32'hD1; tbl[5] = JMPM; tbl[6] = BASE + 32'h40; tbl[7] = JMPM;
    tbl[8] = BASE + 32'h300; tbl[9] = 32'hD2; tbl[10] = ENDM;
    run("jumps", 1'b0);
    // R4: immediate end
    fill(ENDM); tbl[0] = BASE; run("empty", 1'b0);
    // R4: marker neighbours and zero are data
    fill(ENDM); tbl[0] = BASE; tbl[1] = 32'hFFFF_FFFD; tbl[2] = 32'h0; run("near markers", 1'b0);
    // R6: start address one word below base
    fill(ENDM); tbl[0] = BASE - 32'd4; tbl[1] = 32'h55; run("low start", 1'b0);
    // R6: jump below base after writes
    fill(ENDM); tbl[0] = BASE; tbl[1] = 32'h77; tbl[2] = JMPM; tbl[3] = BASE - 32'd1;
    tbl[4] = 32'h88; run("low jump", 1'b0);
    // R7: no end marker
    fill(32'h0000_1234); tbl[0] = BASE; run("overrun", 1'b0);
    // R7: jump marker in last word
    fill(32'h0000_4321); tbl[0] = BASE; tbl[DEPTH-1] = JMPM; run("jump last", 1'b0);
    // R10: start during the quiet delay is ignored
    fill(ENDM); tbl[0] = BASE + 32'h20; tbl[1] = 32'hBEEF; run("start ignored", 1'b1);

    // Generated tables
    x = 32'h1357_9BDF;
    for (int sd = 0; sd < 24; sd++) begin
      lat = sd % 3;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      rdv = x;
      tbl[0] = BASE + (x & 32'hF0);
      for (int i = 1; i < DEPTH; i++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        case (x % 8)
          0: tbl[i] = ENDM;
          1: tbl[i] = JMPM;
          default: tbl[i] = (i > 1 && tbl[i-1] == JMPM) ?
                            (BASE - 32'h40 + (x & 32'h3FC)) : x;
        endcase
      end
      run("generated", 1'b0);
    end

    n_chk++;
    if (hold_viol != 0) begin
      n_fail++;
      $display("FAIL R9 request changed while waiting actual=%0d expected=0", hold_viol);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule